// File: doc/BRIEF.md
# Shared Interrupt Controller with Vector Substitution

This block gathers fourteen single-cycle peripheral event pulses onto one interrupt request line for an 8-bit CPU. Each pulse is held in a sticky request bit until software clears it. A per-source enable mask decides which held requests drive the shared line and which take part in priority resolution. A disabled request stays held and is not lost.

A fixed-priority encoder turns the enabled held requests into a vector byte. The byte is 0x80 plus four times the index of the winning source. When vector substitution is switched on, a CPU code fetch from byte address 0x55 receives that byte in place of the program-memory byte. The memory byte at 0x54 holds the jump-table page, so the CPU's jump through 0x54/0x55 lands on the handler slot for the winning source without any software decoding. On interrupt acknowledge the block gives the CPU the entry address 0x53.

Top module: `shared_irq_autovec`

## Requirements
- R1: After synchronous active-low reset, all request bits, the enable mask and the substitution enable are zero. `irq_o` is low and a fetch from 0x55 returns `mem_data_i`.
- R2: An event pulse on `evt_i[k]` sets request bit k at the next clock edge. The bit stays set after the pulse ends.
- R3: A register write with `reg_sel_i`=1 clears every request bit whose `reg_wdata_i` bit is 1 and leaves the other bits unchanged. If an event and a clear hit the same bit in the same cycle, the event wins and the bit stays set.
- R4: `irq_o` is high exactly when at least one request bit is set and its enable bit is also set.
- R5: A write with `reg_sel_i`=0 loads the enable mask from `reg_wdata_i`. A disabled request stays held and raises `irq_o` as soon as it is enabled.
- R6: Bit index k is priority k+1, and a lower index wins. Bits 0 to 3 are the programmable-level flags of endpoints 2, 4, 6 and 8. Bits 4 to 7 are the empty flags of those endpoints, bits 8 to 11 are their full flags, bit 12 is transfer-engine done and bit 13 is the waveform event. The vector byte is 0x80 + 4*k for the winning k.
- R7: When no enabled request is held, the vector byte is 0x80.
- R8: With substitution enabled, a code fetch (`fetch_code_i`=1) from address 0x55 returns the vector byte in the same cycle.
- R9: A fetch from 0x54, any non-code access, and any access while substitution is disabled all return `mem_data_i` unchanged.
- R10: While `ack_i` is high, `entry_addr_o` is 0x0053. Otherwise it is 0x0000.
- R11: A write with `reg_sel_i`=2 loads the substitution enable from `reg_wdata_i[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | 14 | One-cycle event pulses, one per source |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 enable mask, 1 clear, 2 control |
| reg_wdata_i | input | 14 | Register write data |
| fetch_addr_i | input | 16 | CPU access byte address |
| fetch_code_i | input | 1 | Access is a code fetch |
| mem_data_i | input | 8 | Byte read from program memory |
| fetch_data_o | output | 8 | Byte returned to the CPU |
| irq_o | output | 1 | Shared interrupt request |
| ack_i | input | 1 | Interrupt acknowledge strobe |
| entry_addr_o | output | 16 | Interrupt entry address |

## Verification
Each source is raised alone, and the bench checks that the substituted byte equals 0x80 + 4*k. This shows the index-to-vector mapping is correct for every position. Every ordered pair of sources is then raised together, and the lower index must win. After a clear of only the winner, the other source must take over; this separates a correct priority chain from one reversed or shifted and shows that clears touch only the bits written. A mask sweep over a full set of requests shows the enable gates resolution, not just the line. Fetches from 0x54, non-code accesses and the substitution-off case must pass memory data through untouched.

// File: rtl/irqv_pkg.sv
// Package irqv_pkg
// Shared constants and the register-select encoding for the shared
// interrupt controller. Assumes one 8-bit code-fetch data path.
package irqv_pkg;
    localparam int unsigned NUM_SRC    = 14;
    localparam int unsigned ADDR_W     = 16;
    localparam int unsigned DATA_W     = 8;
    localparam logic [7:0]  VEC_BASE   = 8'h80;
    localparam logic [7:0]  VEC_STEP   = 8'd4;
    localparam logic [15:0] PAGE_ADDR  = 16'h0054;
    localparam logic [15:0] VEC_ADDR   = 16'h0055;
    localparam logic [15:0] ENTRY_ADDR = 16'h0053;

    typedef enum logic [1:0] {
        SEL_ENABLE = 2'd0,
        SEL_CLEAR  = 2'd1,
        SEL_CTRL   = 2'd2
    } reg_sel_e;
endpackage

// File: rtl/irq_pending_regs.sv
// Module irq_pending_regs
// Holds the sticky request bits, the enable mask and the substitution
// enable. Events set bits, write-one clears them, and a set beats a
// clear in the same cycle. Assumes event pulses are synchronous to clk.
module irq_pending_regs
    import irqv_pkg::*;
#(
    parameter int unsigned N = NUM_SRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    input  logic         wr_i,
    input  logic [1:0]   sel_i,
    input  logic [N-1:0] wdata_i,
    output logic [N-1:0] pend_o,
    output logic [N-1:0] mask_o,
    output logic         av_o
);
    logic [N-1:0] pend_q;
    logic [N-1:0] mask_q;
    logic         av_q;
    logic [N-1:0] clr_bits;

    // Decode the write-one-to-clear bits for this cycle.
    always_comb begin
        clr_bits = (wr_i && (sel_i == SEL_CLEAR)) ? wdata_i : '0;
    end

    // Update the request bits, the mask and the control bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            mask_q <= '0;
            av_q   <= 1'b0;
        end else begin
            pend_q <= (pend_q & ~clr_bits) | evt_i;
            if (wr_i && (sel_i == SEL_ENABLE)) begin
                mask_q <= wdata_i;
            end
            if (wr_i && (sel_i == SEL_CTRL)) begin
                av_q <= wdata_i[0];
            end
        end
    end

    assign pend_o = pend_q;
    assign mask_o = mask_q;
    assign av_o   = av_q;
endmodule

// File: rtl/irq_prio_encoder.sv
// Module irq_prio_encoder
// Fixed-priority resolution: the lowest set index wins. Produces the
// any-request flag and the vector byte BASE + STEP*index. With no
// request, the byte equals BASE. Purely combinational.
module irq_prio_encoder
    import irqv_pkg::*;
#(
    parameter int unsigned N = NUM_SRC,
    parameter logic [7:0]  BASE = VEC_BASE,
    parameter logic [7:0]  STEP = VEC_STEP
) (
    input  logic [N-1:0] req_i,
    output logic         any_o,
    output logic [7:0]   vec_o
);
    localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1;

    logic [IDX_W-1:0] idx;

    // Scan from the highest index down, so the lowest set index wins.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

    // Form the request flag and the vector byte.
    always_comb begin
        any_o = |req_i;
        vec_o = BASE + 8'(idx) * STEP;
    end
endmodule

// File: rtl/irq_fetch_mux.sv
// Module irq_fetch_mux
// Replaces the fetched code byte at the vector address with the vector
// byte when substitution is enabled. All other accesses pass memory
// data unchanged. Assumes the address is stable during the fetch cycle.
module irq_fetch_mux
    import irqv_pkg::*;
#(
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned DW = DATA_W,
    parameter logic [15:0] SUB_ADDR = VEC_ADDR
) (
    input  logic [AW-1:0] addr_i,
    input  logic          code_i,
    input  logic          av_i,
    input  logic [DW-1:0] mem_i,
    input  logic [DW-1:0] vec_i,
    output logic [DW-1:0] data_o
);
    // Select the vector byte only for a code fetch at the vector address.
    always_comb begin
        if (av_i && code_i && (addr_i == AW'(SUB_ADDR))) begin
            data_o = vec_i;
        end else begin
            data_o = mem_i;
        end
    end
endmodule

// File: rtl/shared_irq_autovec.sv
// Module shared_irq_autovec
// Top level of the shared interrupt controller. It latches event pulses,
// gates them with the enable mask, drives the shared request, substitutes
// the vector byte into code fetches, and presents the entry address on
// acknowledge. Assumes a single clock and synchronous active-low reset.
module shared_irq_autovec
    import irqv_pkg::*;
#(
    parameter int unsigned N  = NUM_SRC,
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  evt_i,
    input  logic          reg_wr_i,
    input  logic [1:0]    reg_sel_i,
    input  logic [N-1:0]  reg_wdata_i,
    input  logic [AW-1:0] fetch_addr_i,
    input  logic          fetch_code_i,
    input  logic [DW-1:0] mem_data_i,
    output logic [DW-1:0] fetch_data_o,
    output logic          irq_o,
    input  logic          ack_i,
    output logic [AW-1:0] entry_addr_o
);
    logic [N-1:0] pend;
    logic [N-1:0] mask;
    logic         av_en;
    logic [N-1:0] live_req;
    logic [7:0]   vec_byte;

    irq_pending_regs #(.N(N)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (evt_i),
        .wr_i    (reg_wr_i),
        .sel_i   (reg_sel_i),
        .wdata_i (reg_wdata_i),
        .pend_o  (pend),
        .mask_o  (mask),
        .av_o    (av_en)
    );

    // Only enabled held requests take part in the line and in resolution.
    always_comb begin
        live_req = pend & mask;
    end

    irq_prio_encoder #(.N(N)) u_prio (
        .req_i (live_req),
        .any_o (irq_o),
        .vec_o (vec_byte)
    );

    irq_fetch_mux #(.AW(AW), .DW(DW)) u_mux (
        .addr_i (fetch_addr_i),
        .code_i (fetch_code_i),
        .av_i   (av_en),
        .mem_i  (mem_data_i),
        .vec_i  (DW'(vec_byte)),
        .data_o (fetch_data_o)
    );

    // Present the entry address only while the acknowledge is high.
    always_comb begin
        entry_addr_o = ack_i ? AW'(ENTRY_ADDR) : '0;
    end
endmodule

// File: rtl/shared_irq_autovec_chk.sv
// Module shared_irq_autovec_chk
// Assertion checker bound into shared_irq_autovec. It observes the ports
// and the held request, mask and control state.
module shared_irq_autovec_chk
    import irqv_pkg::*;
#(
    parameter int unsigned N  = NUM_SRC,
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned DW = DATA_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic [N-1:0]  evt_i,
    input logic          reg_wr_i,
    input logic [1:0]    reg_sel_i,
    input logic [N-1:0]  reg_wdata_i,
    input logic [AW-1:0] fetch_addr_i,
    input logic          fetch_code_i,
    input logic [DW-1:0] mem_data_i,
    input logic [DW-1:0] fetch_data_o,
    input logic          irq_o,
    input logic          ack_i,
    input logic [AW-1:0] entry_addr_o,
    input logic [N-1:0]  pend,
    input logic [N-1:0]  mask,
    input logic          av_en
);
    logic [N-1:0] clr_now;

    // Bits cleared by a register write in the current cycle.
    always_comb begin
        clr_now = (reg_wr_i && (reg_sel_i == 2'd1)) ? reg_wdata_i : '0;
    end

    assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((pend & $past(evt_i)) == $past(evt_i)));

    assert_clear_hits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((pend & $past(clr_now & ~evt_i)) == '0));

    assert_held_stays_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((($past(pend) & ~$past(clr_now)) & ~pend) == '0));

    assert_idle_vec_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_o && av_en && fetch_code_i && fetch_addr_i == AW'(VEC_ADDR))
            |-> fetch_data_o == DW'(VEC_BASE));

    assert_vec_shape_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (av_en && fetch_code_i && fetch_addr_i == AW'(VEC_ADDR))
            |-> (fetch_data_o[1:0] == 2'b00 && fetch_data_o[7]));

    assert_page_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_addr_i == AW'(PAGE_ADDR) || !av_en || !fetch_code_i)
            |-> fetch_data_o == mem_data_i);

    assert_entry_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |-> entry_addr_o == AW'(ENTRY_ADDR));

    assert_ctrl_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(reg_wr_i) && $past(reg_sel_i) == 2'd2)
            |-> av_en == $past(reg_wdata_i[0]));

    assert_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((pend & mask) != '0));
endmodule

bind shared_irq_autovec shared_irq_autovec_chk #(.N(N), .AW(AW), .DW(DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .evt_i        (evt_i),
    .reg_wr_i     (reg_wr_i),
    .reg_sel_i    (reg_sel_i),
    .reg_wdata_i  (reg_wdata_i),
    .fetch_addr_i (fetch_addr_i),
    .fetch_code_i (fetch_code_i),
    .mem_data_i   (mem_data_i),
    .fetch_data_o (fetch_data_o),
    .irq_o        (irq_o),
    .ack_i        (ack_i),
    .entry_addr_o (entry_addr_o),
    .pend         (pend),
    .mask         (mask),
    .av_en        (av_en)
);

// File: tb/test_shared_irq_autovec.sv
module test_shared_irq_autovec;
    localparam int N = 14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  evt_i = '0;
    logic          reg_wr_i = 1'b0;
    logic [1:0]    reg_sel_i = 2'd0;
    logic [N-1:0]  reg_wdata_i = '0;
    logic [15:0]   fetch_addr_i = 16'h0000;
    logic          fetch_code_i = 1'b0;
    logic [7:0]    mem_data_i = 8'h3C;
    logic [7:0]    fetch_data_o;
    logic          irq_o;
    logic          ack_i = 1'b0;
    logic [15:0]   entry_addr_o;

    int checks = 0;
    int errors = 0;

    shared_irq_autovec i_shared_irq_autovec (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt_i        (evt_i),
        .reg_wr_i     (reg_wr_i),
        .reg_sel_i    (reg_sel_i),
        .reg_wdata_i  (reg_wdata_i),
        .fetch_addr_i (fetch_addr_i),
        .fetch_code_i (fetch_code_i),
        .mem_data_i   (mem_data_i),
        .fetch_data_o (fetch_data_o),
        .irq_o        (irq_o),
        .ack_i        (ack_i),
        .entry_addr_o (entry_addr_o)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] sel, input logic [N-1:0] data);
        @(negedge clk);
        reg_wr_i = 1'b1;
        reg_sel_i = sel;
        reg_wdata_i = data;
        @(negedge clk);
        reg_wr_i = 1'b0;
        reg_wdata_i = '0;
    endtask

    task automatic pulse(input logic [N-1:0] bits);
        @(negedge clk);
        evt_i = bits;
        @(negedge clk);
        evt_i = '0;
    endtask

    function automatic logic [7:0] vec_of(input int k);
        return 8'(8'h80 + 4 * k);
    endfunction

    task automatic fetch(input logic [15:0] addr, input logic code, output logic [7:0] d);
        fetch_addr_i = addr;
        fetch_code_i = code;
        mem_data_i = 8'(addr) ^ 8'h5A;
        #1;
        d = fetch_data_o;
        fetch_code_i = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 irq", 16'(irq_o), 16'h0);
        fetch(16'h0055, 1'b1, d);
        check("R1 fetch 0x55 passes memory", 16'(d), 16'(8'h55 ^ 8'h5A));
        check("R10 entry idle", entry_addr_o, 16'h0000);

        // R11: switch substitution on
        reg_write(2'd2, 14'h0001);

        // R5: disabled request held, raised on enable
        pulse(14'h0008);
        check("R5 disabled request no irq", 16'(irq_o), 16'h0);
        reg_write(2'd0, 14'h0008);
        check("R5 enable raises irq", 16'(irq_o), 16'h1);
        fetch(16'h0055, 1'b1, d);
        check("R5 vector after enable", 16'(d), 16'(vec_of(3)));
        reg_write(2'd1, 14'h3FFF);

        // Single-source sweep
        reg_write(2'd0, 14'h3FFF);
        for (int k = 0; k < N; k++) begin
            pulse(14'(1 << k));
            check("R2 set", 16'(irq_o), 16'h1);
            @(negedge clk);
            check("R2 sticky", 16'(irq_o), 16'h1);
            fetch(16'h0055, 1'b1, d);
            check("R6 R8 vector", 16'(d), 16'(vec_of(k)));
            fetch(16'h0054, 1'b1, d);
            check("R9 page byte", 16'(d), 16'(8'h54 ^ 8'h5A));
            fetch(16'h0055, 1'b0, d);
            check("R9 non-code access", 16'(d), 16'(8'h55 ^ 8'h5A));
            ack_i = 1'b1;
            #1;
            check("R10 entry on ack", entry_addr_o, 16'h0053);
            ack_i = 1'b0;
            reg_write(2'd1, 14'(1 << k));
            check("R3 cleared", 16'(irq_o), 16'h0);
            check("R4 line low", 16'(irq_o), 16'h0);
            fetch(16'h0055, 1'b1, d);
            check("R7 idle vector", 16'(d), 16'h0080);
        end

        // Pair sweep: lower index wins; clearing the winner exposes the other
        for (int a = 0; a < N; a++) begin
            for (int b = a + 1; b < N; b++) begin
                pulse(14'((1 << a) | (1 << b)));
                fetch(16'h0055, 1'b1, d);
                check("R6 pair winner", 16'(d), 16'(vec_of(a)));
                reg_write(2'd1, 14'(1 << a));
                fetch(16'h0055, 1'b1, d);
                check("R3 other bit untouched", 16'(d), 16'(vec_of(b)));
                reg_write(2'd1, 14'h3FFF);
            end
        end

        // Mask sweep over a full request set
        pulse(14'h3FFF);
        for (int k = 0; k < N; k++) begin
            reg_write(2'd0, 14'(1 << k));
            check("R4 masked line", 16'(irq_o), 16'h1);
            fetch(16'h0055, 1'b1, d);
            check("R5 mask gates resolution", 16'(d), 16'(vec_of(k)));
        end
        reg_write(2'd0, 14'h0000);
        check("R4 all masked", 16'(irq_o), 16'h0);
        fetch(16'h0055, 1'b1, d);
        check("R7 all masked vector", 16'(d), 16'h0080);
        reg_write(2'd1, 14'h3FFF);
        reg_write(2'd0, 14'h3FFF);
        check("R3 clear all", 16'(irq_o), 16'h0);

        // R3: event wins over clear in the same cycle
        @(negedge clk);
        evt_i = 14'h0020;
        reg_wr_i = 1'b1;
        reg_sel_i = 2'd1;
        reg_wdata_i = 14'h0020;
        @(negedge clk);
        evt_i = '0;
        reg_wr_i = 1'b0;
        reg_wdata_i = '0;
        check("R3 event beats clear", 16'(irq_o), 16'h1);
        fetch(16'h0055, 1'b1, d);
        check("R3 event beats clear vector", 16'(d), 16'(vec_of(5)));

        // R11: substitution off passes memory data
        reg_write(2'd2, 14'h0000);
        fetch(16'h0055, 1'b1, d);
        check("R11 R9 substitution off", 16'(d), 16'(8'h55 ^ 8'h5A));
        reg_write(2'd2, 14'h0001);
        fetch(16'h0055, 1'b1, d);
        check("R11 substitution back on", 16'(d), 16'(vec_of(5)));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule